// File: doc/BRIEF.md
# Test access port with debug register window

This block is a test access port controller clocked by the test clock. It runs the sixteen-state test-access state machine and holds a 4-bit instruction register. Each instruction selects one data register between the serial input and the serial output. Besides a 32-bit identification register and a 1-bit bypass stage, three instructions open a window onto a debug module. An 8-bit address register chooses a debug register. A 64-bit read register samples that debug register. A 64-bit write register drives a one-cycle write strobe carrying address and data.

The debug bus is synchronous to the test clock and has no handshake. `dbgRdReq` is high during the Capture-DR cycle of the read instruction, and the debug module answers combinationally on `dbgRData` within that cycle. The boundary-scan cell chain lives outside the block. It sees only a select, a mode flag and capture/shift/update strobes. While a boundary instruction is active, the serial path inside the block runs through a one-bit stage.

Top module: `dbgtap_top`

## Requirements
- R1: Five consecutive rising edges of `tck` with `tms` high bring the state machine to Test-Logic-Reset from any state, and the state machine follows the standard sixteen-state transition graph. An active-low `trstN` also forces Test-Logic-Reset asynchronously.
- R2: In Test-Logic-Reset the instruction register holds 4'h1 (identification). Capture-IR loads 4'b0001, and the instruction register shifts least significant bit first.
- R3: Instruction 4'h1 selects a 32-bit register that captures 32'h000018FF and shifts out least significant bit first, with `tdi` entering at the most significant end.
- R4: Instruction 4'h8 selects an 8-bit register that captures the current debug address. On Update-DR it loads the shifted value onto `dbgAddr`. The address returns to 0 in Test-Logic-Reset.
- R5: Instruction 4'h9 selects a 64-bit register. `dbgRdReq` is high for the one Capture-DR cycle, and the register captures `dbgRData` in that cycle.
- R6: Instruction 4'hA selects a 64-bit register that keeps its contents on capture, so it shifts out the previous write value. On Update-DR, `dbgWrStb` is high for exactly one cycle, with `dbgWData` equal to the 64 bits shifted in and `dbgAddr` equal to the current address.
- R7: Instruction 4'hF and every unassigned code (3 to 7, B to E) select a 1-bit bypass stage that captures 0.
- R8: Codes 4'h0 and 4'h2 raise `bsSel`, and code 4'h2 also raises `bsExtest`. `bsCapture`, `bsShift` and `bsUpdate` follow Capture-DR, Shift-DR and Update-DR only under these codes. The serial path goes through a 1-bit stage that captures 0.
- R9: `tdo` and `tdoEn` change only on the falling edge of `tck`. `tdoEn` is high only in the half cycle after a falling edge in Shift-IR or Shift-DR, and `tdo` is 0 while `tdoEn` is low.
- R10: `dbgRdReq` and `dbgWrStb` are never asserted under any instruction other than 4'h9 and 4'hA respectively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trstN | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Mode select, sampled on rising edge |
| tdi | input | 1 | Serial data in, sampled on rising edge |
| tdo | output | 1 | Serial data out, changes on falling edge |
| tdoEn | output | 1 | Serial output valid |
| dbgAddr | output | ADDR_W | Debug register address |
| dbgWData | output | DATA_W | Debug write data |
| dbgWrStb | output | 1 | One-cycle debug write strobe |
| dbgRdReq | output | 1 | Debug read request (Capture-DR of read) |
| dbgRData | input | DATA_W | Debug read data for `dbgAddr` |
| bsSel | output | 1 | Boundary instruction active |
| bsExtest | output | 1 | Boundary instruction drives pads |
| bsCapture | output | 1 | Boundary capture strobe |
| bsShift | output | 1 | Boundary shift strobe |
| bsUpdate | output | 1 | Boundary update strobe |

## Verification
The bench builds the block with its default sizes: an 8-bit address, 64-bit data and the 32-bit identification value. At these sizes all sixteen instruction codes can be swept in two passes, each followed by an 80-bit data scan. Because the scan is longer than the widest register, the tail of every scan shows the selected register's length, and the head shows its captured value. The second pass shows that written data and the address persist from one scan to the next. Separate runs drive the state machine into six different states before the five-high reset sequence, and a half-cycle probe shows the falling-edge timing of the serial output.

// File: rtl/dbgtap_pkg.sv
package dbgtap_pkg;

  localparam int IR_W = 4;
  localparam int ID_W = 32;

  localparam logic [IR_W-1:0] OP_PRELOAD = 4'h0;
  localparam logic [IR_W-1:0] OP_IDCODE  = 4'h1;
  localparam logic [IR_W-1:0] OP_EXTEST  = 4'h2;
  localparam logic [IR_W-1:0] OP_DADDR   = 4'h8;
  localparam logic [IR_W-1:0] OP_DREAD   = 4'h9;
  localparam logic [IR_W-1:0] OP_DWRITE  = 4'hA;
  localparam logic [IR_W-1:0] IR_CAPTURE = 4'b0001;

  typedef enum logic [3:0] {
    ST_TLR, ST_RTI,
    ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
    ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
  } tapState_e;

  typedef enum logic [2:0] {
    SEL_BYP, SEL_ID, SEL_ADDR, SEL_RD, SEL_WR, SEL_BS
  } drSel_e;

  typedef struct packed {
    logic   capDr;
    logic   shDr;
    logic   updDr;
    logic   inReset;
    drSel_e sel;
  } tapCtl_t;

endpackage

// File: rtl/dbgtap_sreg.sv
module dbgtap_sreg #(
  parameter int W = 8
) (
  input  logic         tck,
  input  logic         trstN,
  input  logic         cap,
  input  logic         shf,
  input  logic         tdi,
  input  logic [W-1:0] capVal,
  output logic [W-1:0] q
);

  generate
    if (W == 1) begin : g_single
      always_ff @(posedge tck or negedge trstN) begin
        if (!trstN)   q <= '0;
        else if (cap) q <= capVal;
        else if (shf) q <= tdi;
      end
    end else begin : g_multi
      always_ff @(posedge tck or negedge trstN) begin
        if (!trstN)   q <= '0;
        else if (cap) q <= capVal;
        else if (shf) q <= {tdi, q[W-1:1]};
      end
    end
  endgenerate

endmodule

// File: rtl/dbgtap_ctrl.sv
module dbgtap_ctrl
  import dbgtap_pkg::*;
(
  input  logic    tck,
  input  logic    trstN,
  input  logic    tms,
  input  logic    tdi,
  output tapCtl_t ctl,
  output logic    irTdo,
  output logic    irShifting,
  output logic    bsSel,
  output logic    bsExtest,
  output logic    bsCapture,
  output logic    bsShift,
  output logic    bsUpdate
);

  tapState_e       st, stNext;
  logic [IR_W-1:0] irShift, irReg;

  always_comb begin
    unique case (st)
      ST_TLR:    stNext = tms ? ST_TLR    : ST_RTI;
      ST_RTI:    stNext = tms ? ST_SEL_DR : ST_RTI;
      ST_SEL_DR: stNext = tms ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: stNext = tms ? ST_EX1_DR : ST_SH_DR;
      ST_SH_DR:  stNext = tms ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: stNext = tms ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: stNext = tms ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: stNext = tms ? ST_UPD_DR : ST_SH_DR;
      ST_UPD_DR: stNext = tms ? ST_SEL_DR : ST_RTI;
      ST_SEL_IR: stNext = tms ? ST_TLR    : ST_CAP_IR;
      ST_CAP_IR: stNext = tms ? ST_EX1_IR : ST_SH_IR;
      ST_SH_IR:  stNext = tms ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: stNext = tms ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: stNext = tms ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: stNext = tms ? ST_UPD_IR : ST_SH_IR;
      default:   stNext = tms ? ST_SEL_DR : ST_RTI;
    endcase
  end

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) st <= ST_TLR;
    else        st <= stNext;
  end

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) begin
      irReg   <= OP_IDCODE;
      irShift <= '0;
    end else if (st == ST_TLR) begin
      irReg   <= OP_IDCODE;
    end else begin
      case (st)
        ST_CAP_IR: irShift <= IR_CAPTURE;
        ST_SH_IR:  irShift <= {tdi, irShift[IR_W-1:1]};
        ST_UPD_IR: irReg   <= irShift;
        default: ;
      endcase
    end
  end

  always_comb begin
    ctl         = '0;
    ctl.capDr   = (st == ST_CAP_DR);
    ctl.shDr    = (st == ST_SH_DR);
    ctl.updDr   = (st == ST_UPD_DR);
    ctl.inReset = (st == ST_TLR);
    bsExtest    = 1'b0;
    case (irReg)
      OP_IDCODE:  ctl.sel = SEL_ID;
      OP_DADDR:   ctl.sel = SEL_ADDR;
      OP_DREAD:   ctl.sel = SEL_RD;
      OP_DWRITE:  ctl.sel = SEL_WR;
      OP_PRELOAD: ctl.sel = SEL_BS;
      OP_EXTEST: begin
        ctl.sel  = SEL_BS;
        bsExtest = 1'b1;
      end
      default:    ctl.sel = SEL_BYP;
    endcase
  end

  assign irTdo      = irShift[0];
  assign irShifting = (st == ST_SH_IR);
  assign bsSel      = (ctl.sel == SEL_BS);
  assign bsCapture  = bsSel & ctl.capDr;
  assign bsShift    = bsSel & ctl.shDr;
  assign bsUpdate   = bsSel & ctl.updDr;

  // run length of consecutive tms-high edges, saturating at five
  logic [2:0] tmsRun;
  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN)              tmsRun <= '0;
    else if (!tms)           tmsRun <= '0;
    else if (tmsRun != 3'd5) tmsRun <= tmsRun + 3'd1;
  end

  p_five_high_reset_r1: assert property (@(posedge tck) disable iff (!trstN)
    (tmsRun == 3'd5) |-> (st == ST_TLR));

  p_update_exit_r1: assert property (@(posedge tck) disable iff (!trstN)
    (st == ST_UPD_DR || st == ST_UPD_IR) |=> (st == ST_RTI || st == ST_SEL_DR));

  p_reset_loads_id_r2: assert property (@(posedge tck) disable iff (!trstN)
    (st == ST_TLR) |=> (irReg == OP_IDCODE));

  p_capir_pattern_r2: assert property (@(posedge tck) disable iff (!trstN)
    (st == ST_CAP_IR) |=> (irTdo == 1'b1));

endmodule

// File: rtl/dbgtap_dpath.sv
module dbgtap_dpath
  import dbgtap_pkg::*;
#(
  parameter int              ADDR_W   = 8,
  parameter int              DATA_W   = 64,
  parameter logic [ID_W-1:0] ID_VALUE = 32'h0000_18FF
) (
  input  logic              tck,
  input  logic              trstN,
  input  logic              tdi,
  input  tapCtl_t           ctl,
  input  logic              irTdo,
  input  logic              irShifting,
  input  logic [DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] wData,
  output logic              wrStb,
  output logic              rdReq,
  output logic              tdo,
  output logic              tdoEn
);

  logic              selId, selAddr, selRd, selWr, selByp;
  logic [ID_W-1:0]   idQ;
  logic [ADDR_W-1:0] addrQ, addrReg;
  logic [DATA_W-1:0] rdQ, wrQ;
  logic [0:0]        bypQ;
  logic              drLsb, tdoR, tdoEnR;

  assign selId   = (ctl.sel == SEL_ID);
  assign selAddr = (ctl.sel == SEL_ADDR);
  assign selRd   = (ctl.sel == SEL_RD);
  assign selWr   = (ctl.sel == SEL_WR);
  assign selByp  = (ctl.sel == SEL_BYP) || (ctl.sel == SEL_BS);

  dbgtap_sreg #(.W(ID_W)) u_id (
    .tck(tck), .trstN(trstN), .cap(ctl.capDr & selId), .shf(ctl.shDr & selId),
    .tdi(tdi), .capVal(ID_VALUE), .q(idQ));

  dbgtap_sreg #(.W(ADDR_W)) u_addr (
    .tck(tck), .trstN(trstN), .cap(ctl.capDr & selAddr), .shf(ctl.shDr & selAddr),
    .tdi(tdi), .capVal(addrReg), .q(addrQ));

  dbgtap_sreg #(.W(DATA_W)) u_rd (
    .tck(tck), .trstN(trstN), .cap(ctl.capDr & selRd), .shf(ctl.shDr & selRd),
    .tdi(tdi), .capVal(rdData), .q(rdQ));

  dbgtap_sreg #(.W(DATA_W)) u_wr (
    .tck(tck), .trstN(trstN), .cap(ctl.capDr & selWr), .shf(ctl.shDr & selWr),
    .tdi(tdi), .capVal(wrQ), .q(wrQ));

  dbgtap_sreg #(.W(1)) u_byp (
    .tck(tck), .trstN(trstN), .cap(ctl.capDr & selByp), .shf(ctl.shDr & selByp),
    .tdi(tdi), .capVal(1'b0), .q(bypQ));

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN)                    addrReg <= '0;
    else if (ctl.inReset)          addrReg <= '0;
    else if (ctl.updDr && selAddr) addrReg <= addrQ;
  end

  assign addr  = addrReg;
  assign wData = wrQ;
  assign wrStb = ctl.updDr & selWr;
  assign rdReq = ctl.capDr & selRd;

  always_comb begin
    case (ctl.sel)
      SEL_ID:   drLsb = idQ[0];
      SEL_ADDR: drLsb = addrQ[0];
      SEL_RD:   drLsb = rdQ[0];
      SEL_WR:   drLsb = wrQ[0];
      default:  drLsb = bypQ[0];
    endcase
  end

  always_ff @(negedge tck or negedge trstN) begin
    if (!trstN) begin
      tdoR   <= 1'b0;
      tdoEnR <= 1'b0;
    end else begin
      tdoEnR <= irShifting | ctl.shDr;
      tdoR   <= irShifting ? irTdo : drLsb;
    end
  end

  assign tdo   = tdoR & tdoEnR;
  assign tdoEn = tdoEnR;

  p_addr_hold_r4: assert property (@(posedge tck) disable iff (!trstN)
    !(ctl.updDr && selAddr) && !ctl.inReset |=> $stable(addrReg));

  p_rd_capture_r5: assert property (@(posedge tck) disable iff (!trstN)
    (ctl.capDr && selRd) |=> (rdQ == $past(rdData)));

  p_wrstb_single_r6: assert property (@(posedge tck) disable iff (!trstN)
    wrStb |=> !wrStb);

  p_quiet_in_capture_r9: assert property (@(posedge tck) disable iff (!trstN)
    ctl.capDr |-> !tdoEn);

  p_no_cross_strobe_r10: assert property (@(posedge tck) disable iff (!trstN)
    !(rdReq && wrStb));

endmodule

// File: rtl/dbgtap_top.sv
module dbgtap_top
  import dbgtap_pkg::*;
#(
  parameter int              ADDR_W   = 8,
  parameter int              DATA_W   = 64,
  parameter logic [ID_W-1:0] ID_VALUE = 32'h0000_18FF
) (
  input  logic              tck,
  input  logic              trstN,
  input  logic              tms,
  input  logic              tdi,
  output logic              tdo,
  output logic              tdoEn,
  output logic [ADDR_W-1:0] dbgAddr,
  output logic [DATA_W-1:0] dbgWData,
  output logic              dbgWrStb,
  output logic              dbgRdReq,
  input  logic [DATA_W-1:0] dbgRData,
  output logic              bsSel,
  output logic              bsExtest,
  output logic              bsCapture,
  output logic              bsShift,
  output logic              bsUpdate
);

  tapCtl_t ctl;
  logic    irTdo, irShifting;

  dbgtap_ctrl u_ctrl (
    .tck(tck), .trstN(trstN), .tms(tms), .tdi(tdi),
    .ctl(ctl), .irTdo(irTdo), .irShifting(irShifting),
    .bsSel(bsSel), .bsExtest(bsExtest), .bsCapture(bsCapture),
    .bsShift(bsShift), .bsUpdate(bsUpdate));

  dbgtap_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ID_VALUE(ID_VALUE)) u_dpath (
    .tck(tck), .trstN(trstN), .tdi(tdi), .ctl(ctl),
    .irTdo(irTdo), .irShifting(irShifting), .rdData(dbgRData),
    .addr(dbgAddr), .wData(dbgWData), .wrStb(dbgWrStb), .rdReq(dbgRdReq),
    .tdo(tdo), .tdoEn(tdoEn));

endmodule

// File: tb/tb_dbgtap_top.sv
`timescale 1ns/1ps
module tb_dbgtap_top;

  localparam int AW = 8;
  localparam int DW = 64;
  localparam int SCAN = 80;
  localparam logic [31:0] IDV = 32'h0000_18FF;

  logic tck = 1'b0, trstN = 1'b0, tms = 1'b1, tdi = 1'b0;
  logic tdo, tdoEn, dbgWrStb, dbgRdReq;
  logic bsSel, bsExtest, bsCapture, bsShift, bsUpdate;
  logic [AW-1:0] dbgAddr;
  logic [DW-1:0] dbgWData, dbgRData;

  always #2.5 tck = ~tck;

  // debug module model: read data is a function of the address
  assign dbgRData = 64'h0123_4567_89AB_CDEF ^ {8{dbgAddr}};

  dbgtap_top dut (
    .tck(tck), .trstN(trstN), .tms(tms), .tdi(tdi), .tdo(tdo), .tdoEn(tdoEn),
    .dbgAddr(dbgAddr), .dbgWData(dbgWData), .dbgWrStb(dbgWrStb), .dbgRdReq(dbgRdReq),
    .dbgRData(dbgRData), .bsSel(bsSel), .bsExtest(bsExtest), .bsCapture(bsCapture),
    .bsShift(bsShift), .bsUpdate(bsUpdate));

  int total = 0, bad = 0;
  int rdCnt = 0, wrCnt = 0, bsCapCnt = 0, bsShCnt = 0, bsUpdCnt = 0, extCnt = 0;
  logic [AW-1:0] lastAddr;
  logic [DW-1:0] lastData;
  logic enLow = 1'b0;
  bit done = 0;

  always @(negedge tck) begin
    #0.5;
    if (dbgRdReq) rdCnt++;
    if (dbgWrStb) begin
      wrCnt++;
      lastAddr = dbgAddr;
      lastData = dbgWData;
    end
    if (bsCapture) bsCapCnt++;
    if (bsShift)   bsShCnt++;
    if (bsUpdate)  bsUpdCnt++;
    if (bsShift && bsExtest) extCnt++;
  end

  task automatic chk(input bit ok, input string req, input logic [79:0] act, input logic [79:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic m, input logic d, output logic o);
    tms = m;
    tdi = d;
    @(negedge tck);
    #1 o = tdo;
    @(posedge tck);
    #1;
  endtask

  task automatic shIr(input logic [3:0] v, output logic [3:0] o);
    logic x;
    step(1, 0, x); step(1, 0, x); step(0, 0, x); step(0, 0, x);
    for (int i = 0; i < 4; i++) begin
      step(i == 3, v[i], x);
      o[i] = x;
      if (!tdoEn) enLow = 1'b1;
    end
    step(1, 0, x); step(0, 0, x);
  endtask

  task automatic shDr(input int len, input logic [79:0] v, output logic [79:0] o);
    logic x;
    o = '0;
    step(1, 0, x); step(0, 0, x); step(0, 0, x);
    for (int i = 0; i < len; i++) begin
      step(i == len - 1, v[i], x);
      o[i] = x;
      if (!tdoEn) enLow = 1'b1;
    end
    step(1, 0, x); step(0, 0, x);
  endtask

  initial begin
    repeat (150000) @(posedge tck);
    if (!done) begin
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [3:0]  irO;
    logic [79:0] vIn, vOut, vExp, capV;
    logic [AW-1:0] addrModel;
    logic [DW-1:0] wrModel;
    int wid, rdExp, wrExp;
    logic x;
    addrModel = '0; wrModel = '0; rdExp = 0; wrExp = 0;

    // reset state
    repeat (3) @(posedge tck);
    #1;
    chk(!tdoEn && !tdo && !dbgWrStb && !dbgRdReq && dbgAddr == 0, "R9 reset outputs",
        {tdoEn, tdo, dbgWrStb, dbgRdReq, dbgAddr}, 80'h0);
    @(negedge tck); #1 trstN = 1'b1;
    @(posedge tck); #1;
    step(0, 0, x);
    shDr(32, 80'h0, vOut);
    chk(vOut[31:0] == IDV, "R2 R3 id after reset", vOut, {48'h0, IDV});
    chk(!enLow, "R9 tdoEn high while shifting", {79'h0, enLow}, 80'h0);

    // falling-edge timing of tdo
    step(1, 0, x); step(0, 0, x); step(0, 0, x);
    chk(!tdoEn && !tdo, "R9 no output before falling edge", {tdoEn, tdo}, 80'h0);
    @(negedge tck); #1;
    chk(tdoEn && tdo == IDV[0], "R9 first bit after falling edge", {tdoEn, tdo}, {78'h0, 1'b1, IDV[0]});
    @(posedge tck); #1;
    for (int i = 1; i < 32; i++) step(i == 31, 0, x);
    step(1, 0, x); step(0, 0, x);
    @(negedge tck); #1;
    chk(!tdoEn && !tdo, "R9 quiet in idle", {tdoEn, tdo}, 80'h0);
    @(posedge tck); #1;

    // two sweeps over every instruction code
    for (int pass = 0; pass < 2; pass++) begin
      for (int code = 0; code < 16; code++) begin
        int rd0, bc0, bs0, bu0, ex0;
        shIr(code[3:0], irO);
        chk(irO == 4'b0001, "R2 capture-ir pattern", {76'h0, irO}, 80'h1);
        for (int i = 0; i < SCAN; i++) vIn[i] = (((i * 5 + code * 3 + pass * 11) % 7) < 3);
        capV = '0;
        case (code)
          1:  wid = 32;
          8:  begin wid = AW; capV[AW-1:0] = addrModel; end
          9:  begin wid = DW; capV[DW-1:0] = 64'h0123_4567_89AB_CDEF ^ {8{addrModel}}; rdExp++; end
          10: begin wid = DW; capV[DW-1:0] = wrModel; wrExp++; end
          default: wid = 1;
        endcase
        if (code == 1) capV[31:0] = IDV;
        for (int i = 0; i < SCAN; i++) vExp[i] = (i < wid) ? capV[i] : vIn[i - wid];
        rd0 = rdCnt; bc0 = bsCapCnt; bs0 = bsShCnt; bu0 = bsUpdCnt; ex0 = extCnt;
        shDr(SCAN, vIn, vOut);
        case (code)
          1:  chk(vOut == vExp, "R3 id scan", vOut, vExp);
          8:  chk(vOut == vExp, "R4 address scan", vOut, vExp);
          9:  chk(vOut == vExp, "R5 read scan", vOut, vExp);
          10: chk(vOut == vExp, "R6 write scan", vOut, vExp);
          0, 2: chk(vOut == vExp, "R8 boundary stage scan", vOut, vExp);
          default: chk(vOut == vExp, "R7 bypass scan", vOut, vExp);
        endcase
        if (code == 8) addrModel = vIn[SCAN-1 -: AW];
        if (code == 10) begin
          wrModel = vIn[SCAN-1 -: DW];
          chk(lastAddr == addrModel && lastData == wrModel, "R6 write strobe payload",
              {8'h0, lastAddr, lastData}, {8'h0, addrModel, wrModel});
        end
        chk(dbgAddr == addrModel, "R4 address output", {72'h0, dbgAddr}, {72'h0, addrModel});
        chk(rdCnt == rdExp && wrCnt == wrExp, "R10 R5 R6 strobe counts",
            {48'h0, rdCnt[15:0], wrCnt[15:0]}, {48'h0, rdExp[15:0], wrExp[15:0]});
        if (code == 9) chk(rdCnt - rd0 == 1, "R5 single read request", rdCnt - rd0, 80'h1);
        chk((bsCapCnt - bc0) == ((code == 0 || code == 2) ? 1 : 0) &&
            (bsShCnt - bs0) == ((code == 0 || code == 2) ? SCAN : 0) &&
            (bsUpdCnt - bu0) == ((code == 0 || code == 2) ? 1 : 0) &&
            (extCnt - ex0) == ((code == 2) ? SCAN : 0),
            "R8 boundary strobes",
            {bsCapCnt - bc0, bsShCnt - bs0, bsUpdCnt - bu0, extCnt - ex0},
            {32'(((code == 0 || code == 2) ? 1 : 0)), 32'(((code == 0 || code == 2) ? SCAN : 0)), 16'h0});
      end
    end

    // five tms-high edges from several states
    for (int p = 0; p < 6; p++) begin
      logic [7:0] path;
      int plen;
      shIr(4'h8, irO);
      case (p)
        0: begin path = 8'b0000_0001; plen = 3; end // shift-dr (1,0,0)
        1: begin path = 8'b0000_0101; plen = 4; end // pause-dr
        2: begin path = 8'b0001_0101; plen = 5; end // exit2-dr
        3: begin path = 8'b0000_0011; plen = 4; end // shift-ir
        4: begin path = 8'b0000_1011; plen = 5; end // pause-ir
        default: begin path = 8'b0001_1011; plen = 5; end // update-ir
      endcase
      for (int k = 0; k < plen; k++) step(path[k], 0, x);
      for (int k = 0; k < 5; k++) step(1, 0, x);
      step(0, 0, x);
      shDr(32, 80'h0, vOut);
      chk(vOut[31:0] == IDV, "R1 reset reached, id selected", vOut, {48'h0, IDV});
      chk(dbgAddr == 0, "R4 address cleared by reset", {72'h0, dbgAddr}, 80'h0);
    end
    addrModel = '0;

    // written data survives reset of the state machine
    shIr(4'hA, irO);
    shDr(DW, 80'h0, vOut);
    chk(vOut[DW-1:0] == wrModel, "R6 write register holds value", vOut, {16'h0, wrModel});
    chk(lastAddr == 0 && lastData == 0, "R6 zero write payload", {8'h0, lastAddr, lastData}, 80'h0);
    chk(!enLow, "R9 tdoEn during shifts", {79'h0, enLow}, 80'h0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule